// File: doc/BRIEF.md
# Constant-Gain State-Feedback Control Datapath

This block produces one discrete-time control update for every sample strobe. Each control channel gets a scaled-reference term minus a state-feedback term: u_i = sum over m of N_im * r_m minus sum over j of K_ij * x_j. K has one row per control channel and one column per state. N is square, with one row and one column per channel. Both gain matrices are signed fixed-point constants fixed at elaboration. Every product is realised as a constant-coefficient multiplier, or as a plain shift when the gain is a positive power of two.

Each state, reference and control element has its own slice of a wide parallel port, so all channels are computed at once. The result comes out of a fixed five-register pipeline, and the control word is held between updates, so the value computed from sample k is the one applied at step k+1. Number of states, number of channels, data width, coefficient width and fractional bits are all parameters.

Top module: `sfc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every control output word and the valid flag to zero by the first clock edge at which reset is high.
- R2: Channel i outputs sat(sum_m floor(r_m*N_im / 2^FRAC) - sum_j floor(x_j*K_ij / 2^FRAC)). Each product is formed at full width and then arithmetically shifted right by FRAC bits on its own, before any summation. Gains are signed two's complement with FRAC fractional bits. K element (i,j) sits at bits (i*NUM_STATES+j)*COEF_W of the K vector, and N element (i,m) sits at bits (i*NUM_CH+m)*COEF_W of the N vector. Element e of every data vector occupies bits e*WIDTH upward.
- R3: A strobe sampled high in clock cycle n makes the valid flag high for exactly cycle n+5, carrying that sample's result. The flag is never high at any other time.
- R4: Strobes on consecutive cycles are all accepted, and each produces its own result in order, on consecutive cycles.
- R5: Results above 2^(WIDTH-1)-1 or below -2^(WIDTH-1) are clamped to those limits instead of wrapping.
- R6: The control outputs change only in a cycle where valid is high. State and reference inputs that change while the strobe is low have no effect on any output.
- R7: With K all zero and N equal to identity (diagonal value 2^FRAC), each output equals its reference input from five cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | One-cycle pulse that captures a new sample |
| x_vec | input | NUM_STATES*WIDTH | State vector, one signed element per slice |
| r_vec | input | NUM_CH*WIDTH | Reference vector, one signed element per slice |
| u_vec | output | NUM_CH*WIDTH | Control vector, one signed element per slice, held between updates |
| out_valid | output | 1 | High for one cycle when u_vec carries a new update |

## Verification
The timing properties assume that the strobe is a clean synchronous signal. They also take reset to be synchronous, and they only look as far back as the cycles counted since reset was released, so a strobe seen during reset is never expected to produce a result. The bench changes inputs only on falling edges. It holds the strobe low throughout reset, and scrambles the state and reference inputs while the strobe is low, so the hold property is tested against real input activity. Saturation is reached by driving extreme state and reference words against the default gains, while the dependence on result width is left to the arithmetic model.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   // Registers from the sample strobe to the valid control word.
   localparam int unsigned LATENCY = 5;

   // Width of a signed sum of `terms` operands of width prod_w, with a guard bit.
   function automatic int unsigned sum_width(input int unsigned prod_w, input int unsigned terms);
      return prod_w + $clog2(terms + 1) + 1;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sfc_const_mult.sv
module sfc_const_mult #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned FRAC   = 8,
   parameter logic [COEF_W-1:0] GAIN = '0,
   localparam int unsigned PW = WIDTH + COEF_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [WIDTH-1:0]     din,
   output logic signed [PW-1:0] prod
);
   localparam logic signed [COEF_W-1:0] G = GAIN;
   localparam bit IS_POW2 = (G > 0) && ((G & (G - 1)) == 0);

   logic signed [PW-1:0] full;

   generate
      if (IS_POW2) begin : g_shift
         localparam int unsigned SH = $clog2(int'(G));
         always_comb full = PW'($signed(din)) <<< SH;
      end else begin : g_mult
         always_comb full = PW'($signed(din)) * PW'(G);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= full >>> FRAC;
   end
endmodule

// File: rtl/sfc_row.sv
module sfc_row
   import sfc_pkg::*;
#(
   parameter int unsigned NUM_STATES = 2,
   parameter int unsigned NUM_CH     = 2,
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned COEF_W     = 16,
   parameter int unsigned FRAC       = 8,
   parameter logic [NUM_STATES*COEF_W-1:0] K_ROW = '0,
   parameter logic [NUM_CH*COEF_W-1:0]     N_ROW = '0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_STATES*WIDTH-1:0] x_q,
   input  logic [NUM_CH*WIDTH-1:0]     r_q,
   input  logic                        load,
   output logic [WIDTH-1:0]            u
);
   localparam int unsigned PW = WIDTH + COEF_W;
   localparam int unsigned SW = sum_width(PW, max_u(NUM_STATES, NUM_CH));
   localparam int unsigned DW = SW + 1;

   logic signed [PW-1:0] k_prod [NUM_STATES];
   logic signed [PW-1:0] n_prod [NUM_CH];
   logic signed [SW-1:0] k_acc, n_acc, k_sum, n_sum;
   logic signed [DW-1:0] diff;

   generate
      for (genvar j = 0; j < NUM_STATES; j++) begin : g_k
         sfc_const_mult #(.WIDTH(WIDTH), .COEF_W(COEF_W), .FRAC(FRAC),
                          .GAIN(K_ROW[j*COEF_W +: COEF_W])) u_km (
            .clk(clk), .rst(rst), .din(x_q[j*WIDTH +: WIDTH]), .prod(k_prod[j]));
      end
      for (genvar m = 0; m < NUM_CH; m++) begin : g_n
         sfc_const_mult #(.WIDTH(WIDTH), .COEF_W(COEF_W), .FRAC(FRAC),
                          .GAIN(N_ROW[m*COEF_W +: COEF_W])) u_nm (
            .clk(clk), .rst(rst), .din(r_q[m*WIDTH +: WIDTH]), .prod(n_prod[m]));
      end
   endgenerate

   always_comb begin
      k_acc = '0;
      for (int j = 0; j < NUM_STATES; j++) k_acc += SW'(k_prod[j]);
      n_acc = '0;
      for (int m = 0; m < NUM_CH; m++) n_acc += SW'(n_prod[m]);
   end

   localparam logic signed [DW-1:0] MAX_C = {{(DW-WIDTH+1){1'b0}}, {(WIDTH-1){1'b1}}};
   localparam logic signed [DW-1:0] MIN_C = {{(DW-WIDTH+1){1'b1}}, {(WIDTH-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         k_sum <= '0;
         n_sum <= '0;
         diff  <= '0;
         u     <= '0;
      end else begin
         k_sum <= k_acc;
         n_sum <= n_acc;
         diff  <= DW'(n_sum) - DW'(k_sum);
         if (load) begin
            if (diff > MAX_C)      u <= MAX_C[WIDTH-1:0];
            else if (diff < MIN_C) u <= MIN_C[WIDTH-1:0];
            else                   u <= diff[WIDTH-1:0];
         end
      end
   end
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
   import sfc_pkg::*;
#(
   parameter int unsigned NUM_STATES = 2,
   parameter int unsigned NUM_CH     = 2,
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned COEF_W     = 16,
   parameter int unsigned FRAC       = 8,
   parameter logic [NUM_CH*NUM_STATES*COEF_W-1:0] K_GAINS = 64'h0080_0200_FFC0_0180,
   parameter logic [NUM_CH*NUM_CH*COEF_W-1:0]     N_GAINS = 64'h0300_FF40_0080_0100
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_strobe,
   input  logic [NUM_STATES*WIDTH-1:0] x_vec,
   input  logic [NUM_CH*WIDTH-1:0]     r_vec,
   output logic [NUM_CH*WIDTH-1:0]     u_vec,
   output logic                        out_valid
);
   generate
      if (WIDTH < 8 || WIDTH > 64) begin : g_bad_width
         $error("sfc_ctrl: WIDTH must lie in 8..64");
      end
      if (FRAC >= COEF_W) begin : g_bad_frac
         $error("sfc_ctrl: FRAC must be below COEF_W");
      end
      if (NUM_STATES < 1 || NUM_CH < 1) begin : g_bad_dims
         $error("sfc_ctrl: at least one state and one channel required");
      end
   endgenerate

   logic [NUM_STATES*WIDTH-1:0] x_q;
   logic [NUM_CH*WIDTH-1:0]     r_q;
   logic [LATENCY-1:0]          vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         r_q <= '0;
         vld <= '0;
      end else begin
         if (in_strobe) begin
            x_q <= x_vec;
            r_q <= r_vec;
         end
         vld <= {vld[LATENCY-2:0], in_strobe};
      end
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_row
         sfc_row #(
            .NUM_STATES(NUM_STATES), .NUM_CH(NUM_CH), .WIDTH(WIDTH),
            .COEF_W(COEF_W), .FRAC(FRAC),
            .K_ROW(K_GAINS[i*NUM_STATES*COEF_W +: NUM_STATES*COEF_W]),
            .N_ROW(N_GAINS[i*NUM_CH*COEF_W +: NUM_CH*COEF_W])
         ) u_row (
            .clk(clk), .rst(rst), .x_q(x_q), .r_q(r_q),
            .load(vld[LATENCY-2]), .u(u_vec[i*WIDTH +: WIDTH]));
      end
   endgenerate

   assign out_valid = vld[LATENCY-1];
endmodule

// File: rtl/sfc_ctrl_chk.sv
module sfc_ctrl_chk #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WIDTH  = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_strobe,
   input logic [NUM_CH*WIDTH-1:0] u_vec,
   input logic                    out_valid
);
   logic [2:0] cyc;

   always_ff @(posedge clk) begin
      if (rst)             cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc == 3'd0) |-> (!out_valid && u_vec == '0));

   // R3
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd5 && $past(in_strobe, 5)) |-> out_valid);

   // R3
   valid_source_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (cyc >= 3'd5 && $past(in_strobe, 5)));

   // R6
   output_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd1 && !out_valid) |-> $stable(u_vec));
endmodule

bind sfc_ctrl sfc_ctrl_chk #(.NUM_CH(NUM_CH), .WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .in_strobe(in_strobe), .u_vec(u_vec), .out_valid(out_valid));

// File: tb/sfc_ctrl_tb.sv
`timescale 1ns/1ps
module sfc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strobe = 1'b0;
   logic [31:0] x_vec = '0;
   logic [31:0] r_vec = '0;
   logic [31:0] u_vec, u_id;
   logic        valid, valid_id;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sfc_ctrl u_dut (.clk(clk), .rst(rst), .in_strobe(strobe), .x_vec(x_vec),
                   .r_vec(r_vec), .u_vec(u_vec), .out_valid(valid));

   sfc_ctrl #(.K_GAINS(64'h0), .N_GAINS(64'h0100_0000_0000_0100)) u_dut_id (
      .clk(clk), .rst(rst), .in_strobe(strobe), .x_vec(x_vec),
      .r_vec(r_vec), .u_vec(u_id), .out_valid(valid_id));

   // Q8 gains matching the default parameters: [row][col]
   localparam longint KG [2][2] = '{'{384, -64}, '{512, 128}};
   localparam longint NG [2][2] = '{'{256, 128}, '{-192, 768}};

   // stimulus rows: x0, x1, r0, r1
   localparam logic signed [15:0] VEC [6][4] = '{
      '{16'sd100,    -16'sd50,    16'sd200,   16'sd40},
      '{16'sd0,      16'sd0,      16'sd0,     16'sd0},
      '{-16'sd1,     16'sd1,      -16'sd1,    16'sd1},
      '{16'sd1000,   -16'sd2000,  16'sd300,   -16'sd700},
      '{16'sd32767,  16'sd0,      16'sd0,     16'sd0},
      '{-16'sd32768, -16'sd32768, 16'sd32767, -16'sd32768}
   };

   function automatic longint model(input int ch, input longint x0, input longint x1,
                                    input longint r0, input longint r1);
      longint s;
      s = ((r0 * NG[ch][0]) >>> 8) + ((r1 * NG[ch][1]) >>> 8)
        - ((x0 * KG[ch][0]) >>> 8) - ((x1 * KG[ch][1]) >>> 8);
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   function automatic longint el(input logic [31:0] v, input int i);
      return longint'($signed(v[i*16 +: 16]));
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_one(input logic signed [15:0] x0, input logic signed [15:0] x1,
                          input logic signed [15:0] r0, input logic signed [15:0] r1);
      logic [31:0] held, held_id;
      @(negedge clk);
      x_vec = {x1, x0}; r_vec = {r1, r0}; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      x_vec = ~x_vec; r_vec = r_vec ^ 32'h5a5a_a5a5;   // R6: ignored without strobe
      repeat (3) @(negedge clk);
      chk("R3 valid low at cycle n+4", longint'(valid), 0);
      @(negedge clk);
      chk("R3 valid high at cycle n+5", longint'(valid), 1);
      chk("R2/R5 u0", el(u_vec, 0), model(0, x0, x1, r0, r1));
      chk("R2/R5 u1", el(u_vec, 1), model(1, x0, x1, r0, r1));
      chk("R7 identity u0", el(u_id, 0), longint'(r0));
      chk("R7 identity u1", el(u_id, 1), longint'(r1));
      held = u_vec; held_id = u_id;
      @(negedge clk);
      chk("R3 valid single cycle", longint'(valid), 0);
      chk("R6 output held", longint'(u_vec), longint'(held));
      chk("R6 identity output held", longint'(u_id), longint'(held_id));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk("R1 valid in reset", longint'(valid), 0);
      chk("R1 u in reset", longint'(u_vec), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 u after reset", longint'(u_vec), 0);

      // table walk: R2, R3, R5, R6, R7
      for (int v = 0; v < 6; v++)
         run_one(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

      // R4: three strobes back to back
      @(negedge clk);
      x_vec = {16'sd10, 16'sd20};   r_vec = {16'sd30, 16'sd40};   strobe = 1'b1;
      @(negedge clk);
      x_vec = {-16'sd7, 16'sd300};  r_vec = {16'sd5, -16'sd9};    strobe = 1'b1;
      @(negedge clk);
      x_vec = {16'sd0, -16'sd128};  r_vec = {16'sd1000, 16'sd64}; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 first valid", longint'(valid), 1);
      chk("R4 first u0", el(u_vec, 0), model(0, 20, 10, 40, 30));
      chk("R4 first u1", el(u_vec, 1), model(1, 20, 10, 40, 30));
      @(negedge clk);
      chk("R4 second valid", longint'(valid), 1);
      chk("R4 second u0", el(u_vec, 0), model(0, 300, -7, -9, 5));
      chk("R4 second u1", el(u_vec, 1), model(1, 300, -7, -9, 5));
      @(negedge clk);
      chk("R4 third valid", longint'(valid), 1);
      chk("R4 third u0", el(u_vec, 0), model(0, -128, 0, 64, 1000));
      chk("R4 third u1", el(u_vec, 1), model(1, -128, 0, 64, 1000));
      chk("R7 third identity u1", el(u_id, 1), 1000);
      @(negedge clk);
      chk("R4 burst ends", longint'(valid), 0);

      // R5: explicit positive clamp on both channels
      run_one(16'sd0, 16'sd0, 16'sd32767, 16'sd32767);
      chk("R5 positive clamp u0", el(u_vec, 0), 32767);
      chk("R5 positive clamp u1", el(u_vec, 1), 32767);

      // R1: mid-run reset clears held outputs
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-run u cleared", longint'(u_vec), 0);
      chk("R1 mid-run identity cleared", longint'(u_id), 0);
      chk("R1 mid-run valid cleared", longint'(valid), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule